// File: doc/BRIEF.md
# Majority-Vote Register Read Filter

This block stands in front of a register read path that occasionally returns corrupted data. When a read is requested, it latches the address. It then strobes the target once per clock for a fixed burst of samples and stores every returned word. Afterwards it walks the stored burst and counts how often each distinct word occurs. It returns the most frequent word together with a one-cycle completion pulse.

Counting handles one stored sample per clock. Each sample is compared in parallel against every value already seen. The walk ends early as soon as one value has been seen more often than half the burst length, because no other value can overtake it. Ties between values that reach the same count are settled in favour of the value that reached that count first.

While a read is in progress, the requester may keep `req_valid` asserted or toggle it freely; no second read starts until the pulse on `done` has been given. The result register keeps the last filtered word until the next completion.

Top module: `vote_read_filter`

## Requirements
- R1: While reset is asserted and after its release with no request, `done` and `smp_strobe` are 0 and `result` is 0.
- R2: A request accepted at a clock edge (block idle, `req_valid` high) makes `smp_strobe` high for exactly SAMPLES consecutive cycles, starting in the cycle right after that edge. `smp_addr` equals the accepted `req_addr` throughout. `smp_data` is taken in each strobe cycle.
- R3: `result` is the word that occurs most often among the samples of that read. Among words with equal counts, the word that reached that count earliest in sample order wins.
- R4: Counting stops at the first sample (1-based position P) after which some word has been seen more than SAMPLES/2 times; without such a sample P = SAMPLES. `done` is high in the cycle following the (SAMPLES+P)-th clock edge after the accepting edge.
- R5: `done` is high for exactly one cycle per read. `result` changes only at the edge that raises `done` and holds its value otherwise.
- R6: A request raised while a read is capturing or counting has no effect: no extra strobes, no address change, no second `done`.
- R7: When all samples differ, the first sample is returned and all SAMPLES samples are counted.
- R8: A request raised in the cycle where `done` is high is accepted, and its strobe burst starts in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request; taken only while idle |
| req_addr | input | ADDR_W | Register address of the request |
| smp_strobe | output | 1 | Sample strobe to the target, one word per high cycle |
| smp_addr | output | ADDR_W | Latched address driven to the target |
| smp_data | input | DATA_W | Word returned by the target in the strobe cycle |
| done | output | 1 | One-cycle completion pulse |
| result | output | DATA_W | Filtered (most frequent) word, held between reads |

## Verification
Two coincidences are provoked on purpose. In the first, the completion pulse and the acceptance of the next request fall in the same cycle: a new request is raised while `done` is high. The bench then judges whether the new burst starts one cycle later and whether its result and latency match the model. In the second, a request is raised in the middle of capture and again in the middle of counting. The bench judges whether the strobe count, the driven address and the single completion stay unchanged, and whether the output stays idle afterwards.

// File: rtl/vrf_pkg.sv
package vrf_pkg;

   typedef enum logic [1:0] {
      VRF_IDLE    = 2'd0,
      VRF_CAPTURE = 2'd1,
      VRF_COUNT   = 2'd2
   } vrf_state_e;

endpackage

// File: rtl/vrf_sample_store.sv
module vrf_sample_store #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 100,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem_q[wr_idx] <= wr_data;
      end
   end

   assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/vrf_freq_table.sv
module vrf_freq_table #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 100,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int USE_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              upd_en,
   input  logic [DATA_W-1:0] sample,
   output logic [CNT_W-1:0]  upd_cnt
);

   logic [USE_W-1:0] used_q;
   logic [DEPTH-1:0] hit_vec;
   logic [CNT_W-1:0] gated_cnt [DEPTH];
   logic             any_hit;
   logic [CNT_W-1:0] hit_cnt;

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic [DATA_W-1:0] val_q;
      logic [CNT_W-1:0]  cnt_q;
      logic              live;

      assign live         = USE_W'(e) < used_q;
      assign hit_vec[e]   = live && (val_q == sample);
      assign gated_cnt[e] = hit_vec[e] ? cnt_q : '0;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            val_q <= '0;
            cnt_q <= '0;
         end else if (upd_en) begin
            if (hit_vec[e]) begin
               cnt_q <= cnt_q + CNT_W'(1);
            end else if (!any_hit && (used_q == USE_W'(e))) begin
               val_q <= sample;
               cnt_q <= CNT_W'(1);
            end
         end
      end
   end

   assign any_hit = |hit_vec;

   always_comb begin
      hit_cnt = '0;
      for (int e = 0; e < DEPTH; e++) begin
         hit_cnt = hit_cnt | gated_cnt[e];
      end
   end

   assign upd_cnt = any_hit ? (hit_cnt + CNT_W'(1)) : CNT_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         used_q <= '0;
      end else if (clear) begin
         used_q <= '0;
      end else if (upd_en && !any_hit) begin
         used_q <= used_q + USE_W'(1);
      end
   end

endmodule

// File: rtl/vrf_mode_track.sv
module vrf_mode_track #(
   parameter int DATA_W  = 32,
   parameter int SAMPLES = 100,
   localparam int CNT_W  = $clog2(SAMPLES + 1),
   localparam int HALF   = SAMPLES / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              en,
   input  logic [DATA_W-1:0] sample,
   input  logic [CNT_W-1:0]  upd_cnt,
   output logic [DATA_W-1:0] best_next,
   output logic              majority
);

   logic [DATA_W-1:0] best_q;
   logic [CNT_W-1:0]  max_q;
   logic [CNT_W-1:0]  max_next;
   logic              take;

   assign take      = upd_cnt > max_q;
   assign best_next = take ? sample : best_q;
   assign max_next  = take ? upd_cnt : max_q;
   assign majority  = max_next > CNT_W'(HALF);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         best_q <= '0;
         max_q  <= '0;
      end else if (clear) begin
         best_q <= '0;
         max_q  <= '0;
      end else if (en) begin
         best_q <= best_next;
         max_q  <= max_next;
      end
   end

endmodule

// File: rtl/vote_read_filter.sv
module vote_read_filter
   import vrf_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 8,
   parameter int SAMPLES = 100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              smp_strobe,
   output logic [ADDR_W-1:0] smp_addr,
   input  logic [DATA_W-1:0] smp_data,
   output logic              done,
   output logic [DATA_W-1:0] result
);

   localparam int IDX_W = (SAMPLES > 1) ? $clog2(SAMPLES) : 1;
   localparam int CNT_W = $clog2(SAMPLES + 1);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SAMPLES - 1);

   if (SAMPLES < 2) begin : g_bad_samples
      $error("vote_read_filter: SAMPLES must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("vote_read_filter: DATA_W must be positive");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("vote_read_filter: ADDR_W must be positive");
   end

   vrf_state_e        state_q;
   logic [IDX_W-1:0]  cap_idx_q;
   logic [IDX_W-1:0]  cnt_idx_q;
   logic [ADDR_W-1:0] addr_q;
   logic              done_q;
   logic [DATA_W-1:0] result_q;

   logic              accept;
   logic              capturing;
   logic              counting;
   logic              finish;
   logic [DATA_W-1:0] cur_sample;
   logic [CNT_W-1:0]  upd_cnt;
   logic [DATA_W-1:0] best_next;
   logic              majority;

   assign accept    = (state_q == VRF_IDLE) && req_valid;
   assign capturing = state_q == VRF_CAPTURE;
   assign counting  = state_q == VRF_COUNT;
   assign finish    = counting && (majority || (cnt_idx_q == LAST_IDX));

   vrf_sample_store #(
      .DATA_W (DATA_W),
      .DEPTH  (SAMPLES)
   ) u_store (
      .clk     (clk),
      .wr_en   (capturing),
      .wr_idx  (cap_idx_q),
      .wr_data (smp_data),
      .rd_idx  (cnt_idx_q),
      .rd_data (cur_sample)
   );

   vrf_freq_table #(
      .DATA_W (DATA_W),
      .DEPTH  (SAMPLES)
   ) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (accept),
      .upd_en  (counting),
      .sample  (cur_sample),
      .upd_cnt (upd_cnt)
   );

   vrf_mode_track #(
      .DATA_W  (DATA_W),
      .SAMPLES (SAMPLES)
   ) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (accept),
      .en        (counting),
      .sample    (cur_sample),
      .upd_cnt   (upd_cnt),
      .best_next (best_next),
      .majority  (majority)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= VRF_IDLE;
         cap_idx_q <= '0;
         cnt_idx_q <= '0;
         addr_q    <= '0;
         done_q    <= 1'b0;
         result_q  <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            VRF_IDLE: begin
               if (req_valid) begin
                  state_q   <= VRF_CAPTURE;
                  cap_idx_q <= '0;
                  addr_q    <= req_addr;
               end
            end
            VRF_CAPTURE: begin
               cap_idx_q <= cap_idx_q + IDX_W'(1);
               if (cap_idx_q == LAST_IDX) begin
                  state_q   <= VRF_COUNT;
                  cnt_idx_q <= '0;
               end
            end
            VRF_COUNT: begin
               cnt_idx_q <= cnt_idx_q + IDX_W'(1);
               if (finish) begin
                  state_q  <= VRF_IDLE;
                  done_q   <= 1'b1;
                  result_q <= best_next;
               end
            end
            default: state_q <= VRF_IDLE;
         endcase
      end
   end

   assign smp_strobe = capturing;
   assign smp_addr   = addr_q;
   assign done       = done_q;
   assign result     = result_q;

endmodule

// File: rtl/vrf_checker.sv
module vrf_checker #(
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 8,
   parameter int SAMPLES = 100,
   localparam int RUN_W  = $clog2(SAMPLES + 2)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              smp_strobe,
   input logic [ADDR_W-1:0] smp_addr,
   input logic              done,
   input logic [DATA_W-1:0] result
);

   logic [RUN_W-1:0] run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (smp_strobe) begin
         run_q <= run_q + RUN_W'(1);
      end else begin
         run_q <= '0;
      end
   end

   // R2: every strobe burst is exactly SAMPLES cycles long
   p_burst_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(smp_strobe) |-> (run_q == RUN_W'(SAMPLES)));

   // R2: a burst never runs past SAMPLES cycles
   p_burst_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= RUN_W'(SAMPLES));

   // R5: completion is a single-cycle pulse
   p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R5: the result moves only together with done
   p_result_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (result != $past(result)) |-> done);

   // R6: the driven address is frozen within a burst
   p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_strobe && $past(smp_strobe)) |-> $stable(smp_addr));

   // R6: no strobe overlaps the completion pulse
   p_no_strobe_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !smp_strobe);

   // R8: a request seen together with done starts a burst next cycle
   p_chain_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && req_valid) |=> smp_strobe);

endmodule

bind vote_read_filter vrf_checker #(
   .DATA_W  (DATA_W),
   .ADDR_W  (ADDR_W),
   .SAMPLES (SAMPLES)
) u_vrf_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .smp_strobe (smp_strobe),
   .smp_addr   (smp_addr),
   .done       (done),
   .result     (result)
);

// File: tb/vote_read_filter_tb_top.sv
`timescale 1ns/1ps
module vote_read_filter_tb_top;

   localparam int DW = 32;
   localparam int AW = 8;
   localparam int NS = 100;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          req_valid;
   logic [AW-1:0] req_addr;
   logic          smp_strobe;
   logic [AW-1:0] smp_addr;
   logic [DW-1:0] smp_data;
   logic          done;
   logic [DW-1:0] result;

   logic [DW-1:0] pat [NS];
   int            strobe_cnt;
   logic          cnt_clr;
   int            checks = 0;
   int            errors = 0;

   always #2 clk = ~clk;

   vote_read_filter #(
      .DATA_W  (DW),
      .ADDR_W  (AW),
      .SAMPLES (NS)
   ) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_addr   (req_addr),
      .smp_strobe (smp_strobe),
      .smp_addr   (smp_addr),
      .smp_data   (smp_data),
      .done       (done),
      .result     (result)
   );

   assign smp_data = (strobe_cnt < NS) ? pat[strobe_cnt] : 32'hDEAD_BEEF;

   always @(posedge clk) begin
      if (cnt_clr) strobe_cnt <= 0;
      else if (smp_strobe) strobe_cnt <= strobe_cnt + 1;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic void model(output logic [DW-1:0] res, output int procd);
      logic [DW-1:0] tv [NS];
      int            tc [NS];
      int            used = 0;
      int            mx = 0;
      int            bi = 0;
      procd = NS;
      for (int i = 0; i < NS; i++) begin
         int hit = -1;
         for (int j = 0; j < used; j++) if (tv[j] == pat[i]) hit = j;
         if (hit < 0) begin
            tv[used] = pat[i];
            tc[used] = 1;
            hit = used;
            used++;
         end else begin
            tc[hit]++;
         end
         if (tc[hit] > mx) begin
            mx = tc[hit];
            bi = hit;
         end
         if (mx > NS / 2) begin
            procd = i + 1;
            break;
         end
      end
      res = tv[bi];
   endfunction

   // Starts and ends at a negedge. chain_next leaves it at the done cycle.
   task automatic run_read(input logic [AW-1:0] addr, input bit inject,
                           input bit chain_next, input string rtag,
                           input string stag);
      logic [DW-1:0] er;
      int            ep;
      int            edges = 0;
      int            addr_bad = 0;
      int            stray = 0;
      logic [DW-1:0] held;
      model(er, ep);
      req_addr  = addr;
      req_valid = 1'b1;
      cnt_clr   = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      cnt_clr   = 1'b0;
      check(smp_strobe == 1'b1, stag, "strobe starts after accept", 32'(smp_strobe), 1);
      while (edges <= 2 * NS + 20) begin
         if (smp_strobe && smp_addr != addr) addr_bad++;
         req_valid = inject && (edges == 5 || edges == NS + 2);
         req_addr  = inject ? ~addr : addr;
         @(posedge clk);
         edges++;
         @(negedge clk);
         if (done) break;
      end
      req_valid = 1'b0;
      req_addr  = addr;
      check(done == 1'b1, "R4", "done seen", 32'(done), 1);
      check(edges == NS + ep, "R4", "latency in edges", 32'(edges), 32'(NS + ep));
      check(result == er, rtag, "filtered result", result, er);
      check(strobe_cnt == NS, "R2", "strobe count", 32'(strobe_cnt), NS);
      check(addr_bad == 0, inject ? "R6" : "R2", "address during burst", 32'(addr_bad), 0);
      if (!chain_next) begin
         held = result;
         @(posedge clk);
         @(negedge clk);
         check(done == 1'b0, "R5", "done width", 32'(done), 0);
         check(result == held, "R5", "result held", result, held);
         repeat (3) begin
            @(posedge clk);
            @(negedge clk);
            if (smp_strobe || done) stray++;
         end
         check(stray == 0 && strobe_cnt == NS, inject ? "R6" : "R5",
               "idle after read", 32'(stray), 0);
      end
   endtask

   initial begin
      #600000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [DW-1:0] va, vb;
      void'($urandom(32'd24061));
      rst_n     = 1'b0;
      req_valid = 1'b0;
      req_addr  = '0;
      cnt_clr   = 1'b1;
      for (int i = 0; i < NS; i++) pat[i] = '0;
      repeat (3) @(negedge clk);
      check(done == 0 && smp_strobe == 0, "R1", "outputs in reset",
            {30'd0, done, smp_strobe}, 0);
      check(result == '0, "R1", "result in reset", result, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(done == 0 && smp_strobe == 0 && result == '0, "R1", "idle after reset",
            {30'd0, done, smp_strobe}, 0);

      // all samples equal: majority after 51 samples
      for (int i = 0; i < NS; i++) pat[i] = 32'hA5A5_0001;
      run_read(8'h11, 1'b0, 1'b0, "R4", "R2");

      // alternating A/B: equal counts, A reaches every count first
      va = 32'h1234_5678; vb = 32'h8765_4321;
      for (int i = 0; i < NS; i++) pat[i] = (i % 2 == 0) ? va : vb;
      run_read(8'h22, 1'b0, 1'b0, "R3", "R2");
      for (int i = 0; i < NS; i++) pat[i] = (i % 2 == 0) ? vb : va;
      run_read(8'h23, 1'b0, 1'b0, "R3", "R2");

      // all distinct
      for (int i = 0; i < NS; i++) pat[i] = 32'(i) * 32'h0101_0101 + 32'd7;
      run_read(8'h33, 1'b0, 1'b0, "R7", "R2");

      // majority reached only at the last sample
      for (int i = 0; i < NS; i++) pat[i] = (i < 49) ? 32'(i) + 32'h100 : 32'hCAFE_0000;
      run_read(8'h44, 1'b0, 1'b0, "R4", "R2");

      // exactly half plus distinct rest: no early stop
      for (int i = 0; i < NS; i++) pat[i] = (i % 2 == 1) ? 32'h5555_AAAA : 32'(i) + 32'h900;
      run_read(8'h45, 1'b0, 1'b0, "R3", "R2");

      // requests during capture and counting are ignored
      for (int i = 0; i < NS; i++) pat[i] = (i % 3 == 0) ? 32'h0BAD_F00D : 32'(i % 7);
      run_read(8'h5A, 1'b1, 1'b0, "R6", "R2");

      // back-to-back: next request raised in the done cycle
      for (int i = 0; i < NS; i++) pat[i] = 32'h7777_0000 + 32'(i % 4);
      run_read(8'h66, 1'b0, 1'b1, "R3", "R2");
      for (int i = 0; i < NS; i++) pat[i] = (i % 5 == 0) ? 32'h3 : 32'hFFFF_0000 + 32'(i % 3);
      run_read(8'h67, 1'b0, 1'b0, "R3", "R8");

      // constrained random: small alphabets with random skew
      for (int r = 0; r < 10; r++) begin
         logic [DW-1:0] alpha [6];
         int k    = 2 + int'($urandom % 5);
         int bias = int'($urandom % 80);
         for (int j = 0; j < 6; j++) alpha[j] = $urandom;
         for (int i = 0; i < NS; i++) begin
            if (int'($urandom % 100) < bias) pat[i] = alpha[0];
            else pat[i] = alpha[$urandom % k];
         end
         run_read(8'($urandom), 1'b0, 1'b0, "R3", "R2");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule